// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for every beat of a four-beat burst into a synchronous memory. An address-strobe event captures an external address. Each later advance produces the next address in the burst. Only the two least-significant bits change during a burst. The upper bits stay at the captured value. The low bits follow one of two orders, chosen by a static order input: binary count with wrap, or XOR of the start value with the beat number.

Two strobes can start a burst. The processor-side strobe loads only when the primary chip enable is active. The controller-side strobe loads unconditionally. When no load occurs, the advance input chooses between stepping to the next beat and holding the current address for a wait cycle. A one-cycle flag marks the first beat of every new burst. The memory array, data path and write control sit outside this block.

Top module: `burst_seq_gen`

## Requirements
- R1: While rst_ni is low and after its release, addr_o is all zeros and start_o is 0, until the first load.
- R2: With ctl_strobe_ni low at a rising edge, addr_i is captured whatever sel_ni is. After that edge, addr_o equals the captured addr_i and start_o is 1.
- R3: With cpu_strobe_ni low and sel_ni low at a rising edge, addr_i is captured. With sel_ni high and ctl_strobe_ni high, cpu_strobe_ni has no effect, and the edge acts as a hold or a step as set by adv_ni.
- R4: Linear order (order_i = 0 sampled at load): on beat n, addr_o[1:0] = (start + n) mod 4. For example, start 3 gives 3, 0, 1, 2.
- R5: Interleaved order (order_i = 1 sampled at load): on beat n, addr_o[1:0] = start XOR n. For example, start 1 gives 1, 0, 3, 2, and start 2 gives 2, 3, 0, 1.
- R6: addr_o bits above bit 1 stay equal to the captured addr_i bits until the next load.
- R7: With both strobes inactive (or the processor strobe gated off) and adv_ni high, addr_o holds its value at the edge.
- R8: A load takes priority over advancing. Both strobes active in the same cycle form a single load.
- R9: Advances after the fourth beat keep wrapping through the same four addresses.
- R10: order_i is sampled only at a load. Changing it during a burst does not alter the sequence.
- R11: start_o is 1 only in the cycle that follows a load edge. After any hold or step edge it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External start address |
| cpu_strobe_ni | input | 1 | Processor-side load strobe, active low, gated by sel_ni |
| ctl_strobe_ni | input | 1 | Controller-side load strobe, active low, not gated |
| sel_ni | input | 1 | Primary chip enable, active low |
| adv_ni | input | 1 | Advance to next beat, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst word address |
| start_o | output | 1 | First beat of a new burst |

## Verification
Every state register drives addr_o through combinational logic only, so a wrong beat count, base or captured order shows up as a wrong address in the cycle right after the edge that caused it. An order captured wrongly stays hidden on beat 0. It first appears at the second beat, where linear and interleaved diverge for every odd start value. A wrongly gated strobe shows up as an unexpected start_o pulse and a jump in the upper address bits in the next cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } burst_act_e;
endpackage

// File: rtl/burst_load_dec.sv
module burst_load_dec
  import burst_seq_pkg::*;
(
  input  logic       cpu_strobe_ni,
  input  logic       ctl_strobe_ni,
  input  logic       sel_ni,
  input  logic       adv_ni,
  output burst_act_e act_o
);
  logic cpu_load, ctl_load;

  assign cpu_load = !cpu_strobe_ni && !sel_ni;
  assign ctl_load = !ctl_strobe_ni;

  always_comb begin
    if (cpu_load || ctl_load) act_o = ACT_LOAD;
    else if (!adv_ni)         act_o = ACT_STEP;
    else                      act_o = ACT_HOLD;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int BB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  burst_act_e    act_i,
  input  burst_order_e  order_i,
  output logic [BB-1:0] beat_o,
  output burst_order_e  order_o,
  output logic          start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o  <= '0;
      order_o <= ORD_LINEAR;
      start_o <= 1'b0;
    end else begin
      start_o <= (act_i == ACT_LOAD);
      unique case (act_i)
        ACT_LOAD: begin
          beat_o  <= '0;
          order_o <= order_i;
        end
        ACT_STEP: beat_o <= beat_o + 1'b1; // wraps modulo 2**BB
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_seq_pkg::*;
#(
  parameter int AW = 17,
  parameter int BB = 2
) (
  input  logic [AW-1:0] base_i,
  input  logic [BB-1:0] beat_i,
  input  burst_order_e  order_i,
  output logic [AW-1:0] addr_o
);
  logic [BB-1:0] low;

  always_comb begin
    if (order_i == ORD_XOR) low = base_i[BB-1:0] ^ beat_i;
    else                    low = base_i[BB-1:0] + beat_i;
  end

  assign addr_o = {base_i[AW-1:BB], low};
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BURST_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_strobe_ni,
  input  logic              ctl_strobe_ni,
  input  logic              sel_ni,
  input  logic              adv_ni,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              start_o
);
  localparam int BB = BURST_BITS;

  burst_act_e    act;
  burst_order_e  order_q;
  logic [BB-1:0] beat_q;
  logic [ADDR_W-1:0] base_q;

  burst_load_dec u_dec (
    .cpu_strobe_ni (cpu_strobe_ni),
    .ctl_strobe_ni (ctl_strobe_ni),
    .sel_ni        (sel_ni),
    .adv_ni        (adv_ni),
    .act_o         (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               base_q <= '0;
    else if (act == ACT_LOAD)  base_q <= addr_i;
  end

  burst_beat_ctr #(.BB(BB)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .order_i (burst_order_e'(order_i)),
    .beat_o  (beat_q),
    .order_o (order_q),
    .start_o (start_o)
  );

  burst_addr_map #(.AW(ADDR_W), .BB(BB)) u_map (
    .base_i  (base_q),
    .beat_i  (beat_q),
    .order_i (order_q),
    .addr_o  (addr_o)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 17,
  parameter int BB = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          cpu_strobe_ni,
  input logic          ctl_strobe_ni,
  input logic          sel_ni,
  input logic          adv_ni,
  input logic [AW-1:0] addr_o,
  input logic          start_o,
  input logic          order_q
);
  logic ld;
  assign ld = !ctl_strobe_ni || (!cpu_strobe_ni && !sel_ni);

  // R2
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> (addr_o == $past(addr_i)) && start_o);

  // R3
  gated_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_strobe_ni && sel_ni && ctl_strobe_ni && adv_ni) |=> $stable(addr_o) && !start_o);

  // R6
  upper_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> addr_o[AW-1:BB] == $past(addr_o[AW-1:BB]));

  // R7
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && adv_ni) |=> $stable(addr_o));

  // R4
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && !adv_ni && !order_q) |=> addr_o[BB-1:0] == BB'($past(addr_o[BB-1:0]) + 1'b1));

  // R11
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> !start_o);

  // R10
  order_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> $stable(order_q));
endmodule

bind burst_seq_gen burst_seq_chk #(.AW(ADDR_W), .BB(BURST_BITS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .cpu_strobe_ni (cpu_strobe_ni),
  .ctl_strobe_ni (ctl_strobe_ni),
  .sel_ni        (sel_ni),
  .adv_ni        (adv_ni),
  .addr_o        (addr_o),
  .start_o       (start_o),
  .order_q       (order_q)
);

// File: tb/sim_burst_seq_gen.sv
module sim_burst_seq_gen;
  localparam int AW = 17;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic cpu_strobe_ni = 1'b1, ctl_strobe_ni = 1'b1, sel_ni = 1'b1, adv_ni = 1'b1, order_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic start_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model state
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_ord = 1'b0;
  logic          m_start = 1'b0;

  always #2 clk_i = ~clk_i;

  burst_seq_gen u0 (.*);

  function automatic logic [1:0] low_of(logic [1:0] s, logic [1:0] n, logic ord);
    if (ord) return s ^ n;
    return s + n;
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    return {m_base[AW-1:2], low_of(m_base[1:0], m_beat, m_ord)};
  endfunction

  task automatic check(string tag, logic [AW-1:0] a_exp, logic s_exp);
    checks++;
    if (addr_o !== a_exp || start_o !== s_exp) begin
      errors++;
      $display("FAIL %s addr=%h start=%b expected addr=%h start=%b", tag, addr_o, start_o, a_exp, s_exp);
    end
  endtask

  task automatic step(string tag, logic [AW-1:0] a, logic cpu, logic ctl, logic sel,
                      logic adv, logic ord);
    @(negedge clk_i);
    addr_i = a; cpu_strobe_ni = cpu; ctl_strobe_ni = ctl; sel_ni = sel; adv_ni = adv; order_i = ord;
    @(posedge clk_i);
    if (!ctl || (!cpu && !sel)) begin
      m_base = a; m_beat = 2'd0; m_ord = ord; m_start = 1'b1;
    end else begin
      m_start = 1'b0;
      if (!adv) m_beat = m_beat + 2'd1;
    end
    #1;
    check(tag, exp_addr(), m_start);
  endtask

  task automatic expect_low(string tag, logic [1:0] v);
    checks++;
    if (addr_o[1:0] !== v) begin
      errors++;
      $display("FAIL %s low=%0d expected low=%0d", tag, addr_o[1:0], v);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #5;
    check("R1 in reset", '0, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    step("R1 idle after reset", 17'h1abcd, 1, 1, 0, 1, 0);

    // R2: controller strobe ignores chip enable
    step("R2 ctl load sel high", 17'h12345, 1, 0, 1, 1, 0);
    // R3: gated processor strobe, hold
    step("R3 cpu gated", 17'h0ffff, 0, 1, 1, 1, 0);
    // R3: gated processor strobe, step
    step("R3 cpu gated step", 17'h0ffff, 0, 1, 1, 0, 0);
    step("R3 cpu load", 17'h0aaa3, 0, 1, 0, 1, 0);

    // R4 linear from 3: 3,0,1,2
    expect_low("R4 beat0", 2'd3);
    step("R4 b1", 17'h0, 1, 1, 1, 0, 1); expect_low("R4 beat1", 2'd0);
    step("R4 b2", 17'h0, 1, 1, 1, 0, 1); expect_low("R4 beat2", 2'd1);  // R10 order_i changed
    step("R7 wait", 17'h0, 1, 1, 1, 1, 1); expect_low("R7 held", 2'd1);
    step("R4 b3", 17'h0, 1, 1, 1, 0, 0); expect_low("R4 beat3", 2'd2);
    step("R9 wrap", 17'h0, 1, 1, 1, 0, 0); expect_low("R9 beat4", 2'd3);
    step("R9 wrap2", 17'h0, 1, 1, 1, 0, 0); expect_low("R9 beat5", 2'd0);

    // R5 interleaved from 1: 1,0,3,2
    step("R5 load1", 17'h15551, 1, 0, 0, 1, 1); expect_low("R5 s1 b0", 2'd1);
    step("R5 s1", 17'h0, 1, 1, 1, 0, 0); expect_low("R5 s1 b1", 2'd0);
    step("R5 s1", 17'h0, 1, 1, 1, 0, 0); expect_low("R5 s1 b2", 2'd3);
    step("R5 s1", 17'h0, 1, 1, 1, 0, 0); expect_low("R5 s1 b3", 2'd2);
    // R5 interleaved from 2: 2,3,0,1
    step("R5 load2", 17'h08882, 0, 1, 0, 1, 1);
    step("R5 s2", 17'h0, 1, 1, 1, 0, 0); expect_low("R5 s2 b1", 2'd3);
    step("R5 s2", 17'h0, 1, 1, 1, 0, 0); expect_low("R5 s2 b2", 2'd0);
    step("R5 s2", 17'h0, 1, 1, 1, 0, 0); expect_low("R5 s2 b3", 2'd1);

    // R8 both strobes and advance low: one load, no step
    step("R8 both strobes", 17'h1f00e, 0, 0, 0, 0, 0);
    expect_low("R8 beat0", 2'd2);
    step("R8 reload over adv", 17'h0c00d, 1, 0, 1, 0, 0);
    step("R11 step clears start", 17'h1ffff, 1, 1, 1, 0, 0);
    step("R6 upper kept", 17'h1ffff, 1, 1, 1, 0, 1);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      logic cpu, ctl;
      a = AW'($urandom);
      cpu = ($urandom_range(0, 3) != 0);
      ctl = ($urandom_range(0, 5) != 0);
      step("RND", a, cpu, ctl, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // async reset mid-burst
    @(negedge clk_i); rst_ni = 1'b0; #1;
    check("R1 reset again", '0, 1'b0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule